// File: doc/BRIEF.md
# Evaluation Stack Register File

This block holds the operand storage of a stack-oriented datapath: a circular stack buffer addressed by a top pointer, a bank of general local registers, a bank of auxiliary registers and a small bank of constants that only a configuration port can load. Each instruction offers two source operands and one destination. Every operand is picked by a selector that names either a register by index or a position relative to the stack top: the top, the entry below it, or the slot above it for a push. A source selector can also ask for its stack entry to be popped once it has been read.

Pops and pushes do not move the pointer while the instruction is in flight. Each pop adds minus one and each push adds plus one to a per-instruction delta. Every address inside the instruction is formed from the pointer as it stood before the instruction, and the delta is added once the instruction completes. A short "quick" form replaces the first source and the destination with one of four fixed pairings chosen by a 2-bit code. An instruction that names both a local and an auxiliary register is refused: it raises an illegal-operand flag, writes nothing and leaves the pointer alone.

Top module: `esrf_top`

## Requirements
- R1: After reset the stack pointer `sp` is 0, `illegal` is 0 and both read outputs are 0.
- R2: Source kind codes are 0 none (reads 0), 1 local, 2 constant, 3 auxiliary, 4 top [S], 5 next [S-1], 6 top with pop, 7 next with pop. The index field picks the register. The read value appears on the read output one cycle after `op_valid` and reflects the state before that instruction's write.
- R3: Destination kind codes are 0 none, 1 local, 2 constant, 3 auxiliary, 4 top [S], 5 next [S-1], 6 push [S+1], and 7, which acts as none. With `op_valid` set, `wr_data` is written there at the same clock edge.
- R4: Each pop selector adds -1 and a push destination adds +1 to the instruction's delta. All stack addresses of the instruction use the pointer from before the instruction. `sp` takes the new value one cycle after `op_valid`, modulo 128.
- R5: An instruction whose sources or destination include both a local and an auxiliary register sets `illegal` for one cycle, writes nothing and leaves `sp` unchanged. Its reads are still performed.
- R6: Constants 0 to 11 are loaded only through `cfg_we`/`cfg_idx`/`cfg_data`. A configuration index from 12 to 15 is ignored, a constant read with an index from 12 to 15 returns 0, and a destination of kind constant writes nothing.
- R7: When `quick_en` is set, `quick_code` replaces source A and the destination: 0 gives dest [S] with source [S]; 1 gives a push with source [S]; 2 gives a push with source constant 0; 3 gives a push with source constant 1. Source B is unaffected.
- R8: In a cycle without `op_valid`, `sp` and both read outputs hold their values and `illegal` reads 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Constant load strobe |
| cfg_idx | input | 4 | Constant index to load |
| cfg_data | input | 32 | Constant value |
| op_valid | input | 1 | Instruction present and completing this cycle |
| quick_en | input | 1 | Use the quick pairing for source A and destination |
| quick_code | input | 2 | Quick pairing code |
| src_a_kind | input | 3 | Source A selector kind |
| src_a_idx | input | 4 | Source A register index |
| src_b_kind | input | 3 | Source B selector kind |
| src_b_idx | input | 4 | Source B register index |
| dst_kind | input | 3 | Destination selector kind |
| dst_idx | input | 4 | Destination register index |
| wr_data | input | 32 | Value written to the destination |
| rd_a_data | output | 32 | Source A value, registered |
| rd_b_data | output | 32 | Source B value, registered |
| sp | output | 7 | Stack top pointer |
| illegal | output | 1 | Previous instruction mixed local and auxiliary registers |

## Verification
The hardest situation to reach is one instruction that pops twice and pushes once. It must read both old entries at the pre-instruction pointer and write the slot above the old top. After that it must land the pointer one below where it started. The stimulus first fills part of the stack with pushes, then issues that combination and reads the slots back. The same approach, pops from a nearly empty stack, drives the pointer across the wrap from 0 to 127. The behavioural model marks stack slots that were never written, so their contents are not compared.

// File: rtl/esrf_pkg.sv
package esrf_pkg;
  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_LOC     = 3'd1,
    SRC_CON     = 3'd2,
    SRC_AUX     = 3'd3,
    SRC_TOP     = 3'd4,
    SRC_NXT     = 3'd5,
    SRC_TOP_POP = 3'd6,
    SRC_NXT_POP = 3'd7
  } src_kind_e;

  typedef enum logic [2:0] {
    DST_NONE = 3'd0,
    DST_LOC  = 3'd1,
    DST_CON  = 3'd2,
    DST_AUX  = 3'd3,
    DST_TOP  = 3'd4,
    DST_NXT  = 3'd5,
    DST_PUSH = 3'd6,
    DST_RSV  = 3'd7
  } dst_kind_e;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_LOC  = 3'd1,
    BK_CON  = 3'd2,
    BK_AUX  = 3'd3,
    BK_STK  = 3'd4
  } bank_e;
endpackage

// File: rtl/esrf_bank.sv
module esrf_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_a <= mem[raddr_a];
      rdata_b <= mem[raddr_b];
    end
  end

  p_waddr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/esrf_src_res.sv
module esrf_src_res
  import esrf_pkg::*;
#(
  parameter int RIW  = 4,
  parameter int SPW  = 7,
  parameter int NCON = 12
) (
  input  src_kind_e        kind,
  input  logic [RIW-1:0]   idx,
  input  logic [SPW-1:0]   sp_cur,
  output bank_e            bank,
  output logic [RIW-1:0]   ridx,
  output logic [SPW-1:0]   sidx,
  output logic             pop
);
  always_comb begin
    bank = BK_NONE;
    ridx = idx;
    sidx = sp_cur;
    pop  = 1'b0;
    unique case (kind)
      SRC_LOC: bank = BK_LOC;
      SRC_CON: bank = (int'(idx) < NCON) ? BK_CON : BK_NONE;
      SRC_AUX: bank = BK_AUX;
      SRC_TOP: bank = BK_STK;
      SRC_NXT: begin
        bank = BK_STK;
        sidx = sp_cur - SPW'(1);
      end
      SRC_TOP_POP: begin
        bank = BK_STK;
        pop  = 1'b1;
      end
      SRC_NXT_POP: begin
        bank = BK_STK;
        sidx = sp_cur - SPW'(1);
        pop  = 1'b1;
      end
      default: bank = BK_NONE;
    endcase
  end

  always_comb begin
    a_pop_on_stack_r4: assert (!pop || bank == BK_STK);
  end
endmodule

// File: rtl/esrf_dst_res.sv
module esrf_dst_res
  import esrf_pkg::*;
#(
  parameter int RIW = 4,
  parameter int SPW = 7
) (
  input  dst_kind_e        kind,
  input  logic [RIW-1:0]   idx,
  input  logic [SPW-1:0]   sp_cur,
  output bank_e            bank,
  output logic [RIW-1:0]   ridx,
  output logic [SPW-1:0]   sidx,
  output logic             push
);
  always_comb begin
    bank = BK_NONE;
    ridx = idx;
    sidx = sp_cur;
    push = 1'b0;
    unique case (kind)
      DST_LOC: bank = BK_LOC;
      DST_AUX: bank = BK_AUX;
      DST_TOP: bank = BK_STK;
      DST_NXT: begin
        bank = BK_STK;
        sidx = sp_cur - SPW'(1);
      end
      DST_PUSH: begin
        bank = BK_STK;
        sidx = sp_cur + SPW'(1);
        push = 1'b1;
      end
      default: bank = BK_NONE;
    endcase
  end

  always_comb begin
    a_con_never_written_r6: assert (!(kind == DST_CON) || bank == BK_NONE);
  end
endmodule

// File: rtl/esrf_top.sv
module esrf_top
  import esrf_pkg::*;
#(
  parameter int W    = 32,
  parameter int RIW  = 4,
  parameter int NCON = 12,
  parameter int SPW  = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [RIW-1:0] cfg_idx,
  input  logic [W-1:0]   cfg_data,
  input  logic           op_valid,
  input  logic           quick_en,
  input  logic [1:0]     quick_code,
  input  logic [2:0]     src_a_kind,
  input  logic [RIW-1:0] src_a_idx,
  input  logic [2:0]     src_b_kind,
  input  logic [RIW-1:0] src_b_idx,
  input  logic [2:0]     dst_kind,
  input  logic [RIW-1:0] dst_idx,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   rd_a_data,
  output logic [W-1:0]   rd_b_data,
  output logic [SPW-1:0] sp,
  output logic           illegal
);
  localparam int NREG   = 1 << RIW;
  localparam int SDEPTH = 1 << SPW;
  localparam int NPORT  = 2;

  // quick-form override of source A and destination
  src_kind_e      s_kind [NPORT];
  logic [RIW-1:0] s_idx  [NPORT];
  dst_kind_e      d_kind;

  always_comb begin
    s_kind[0] = src_kind_e'(src_a_kind);
    s_idx[0]  = src_a_idx;
    s_kind[1] = src_kind_e'(src_b_kind);
    s_idx[1]  = src_b_idx;
    d_kind    = dst_kind_e'(dst_kind);
    if (quick_en) begin
      unique case (quick_code)
        2'd0: begin s_kind[0] = SRC_TOP; d_kind = DST_TOP;  end
        2'd1: begin s_kind[0] = SRC_TOP; d_kind = DST_PUSH; end
        2'd2: begin s_kind[0] = SRC_CON; s_idx[0] = RIW'(0); d_kind = DST_PUSH; end
        default: begin s_kind[0] = SRC_CON; s_idx[0] = RIW'(1); d_kind = DST_PUSH; end
      endcase
    end
  end

  logic [SPW-1:0] sp_q;
  bank_e          s_bank [NPORT];
  logic [RIW-1:0] s_ridx [NPORT];
  logic [SPW-1:0] s_sidx [NPORT];
  logic           s_pop  [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_src
    esrf_src_res #(.RIW(RIW), .SPW(SPW), .NCON(NCON)) u_res (
      .kind  (s_kind[g]),
      .idx   (s_idx[g]),
      .sp_cur(sp_q),
      .bank  (s_bank[g]),
      .ridx  (s_ridx[g]),
      .sidx  (s_sidx[g]),
      .pop   (s_pop[g])
    );
  end

  bank_e          d_bank;
  logic [RIW-1:0] d_ridx;
  logic [SPW-1:0] d_sidx;
  logic           d_push;

  esrf_dst_res #(.RIW(RIW), .SPW(SPW)) u_dst (
    .kind  (d_kind),
    .idx   (dst_idx),
    .sp_cur(sp_q),
    .bank  (d_bank),
    .ridx  (d_ridx),
    .sidx  (d_sidx),
    .push  (d_push)
  );

  // local / auxiliary mixing rule
  logic uses_loc, uses_aux, illegal_c, commit;
  always_comb begin
    uses_loc = (s_kind[0] == SRC_LOC) || (s_kind[1] == SRC_LOC) || (d_kind == DST_LOC);
    uses_aux = (s_kind[0] == SRC_AUX) || (s_kind[1] == SRC_AUX) || (d_kind == DST_AUX);
  end
  assign illegal_c = op_valid && uses_loc && uses_aux;
  assign commit    = op_valid && !illegal_c;

  // deferred stack delta
  logic [2:0]     delta;
  logic [SPW-1:0] delta_ext;
  assign delta     = 3'(d_push) - 3'(s_pop[0]) - 3'(s_pop[1]);
  assign delta_ext = {{(SPW-3){delta[2]}}, delta};

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= illegal_c;
      if (commit) sp_q <= sp_q + delta_ext;
    end
  end
  assign sp = sp_q;

  // bank write enables
  logic loc_we, aux_we, stk_we, con_we;
  assign loc_we = commit && (d_bank == BK_LOC);
  assign aux_we = commit && (d_bank == BK_AUX);
  assign stk_we = commit && (d_bank == BK_STK);
  assign con_we = cfg_we && (int'(cfg_idx) < NCON);

  logic [W-1:0] loc_a, loc_b, aux_a, aux_b, con_a, con_b, stk_a, stk_b;

  esrf_bank #(.W(W), .DEPTH(NREG), .AW(RIW)) u_loc (
    .clk(clk), .rst(rst), .we(loc_we), .waddr(d_ridx), .wdata(wr_data),
    .re(op_valid), .raddr_a(s_ridx[0]), .raddr_b(s_ridx[1]),
    .rdata_a(loc_a), .rdata_b(loc_b)
  );

  esrf_bank #(.W(W), .DEPTH(NREG), .AW(RIW)) u_aux (
    .clk(clk), .rst(rst), .we(aux_we), .waddr(d_ridx), .wdata(wr_data),
    .re(op_valid), .raddr_a(s_ridx[0]), .raddr_b(s_ridx[1]),
    .rdata_a(aux_a), .rdata_b(aux_b)
  );

  esrf_bank #(.W(W), .DEPTH(NCON), .AW(RIW)) u_con (
    .clk(clk), .rst(rst), .we(con_we), .waddr(cfg_idx), .wdata(cfg_data),
    .re(op_valid), .raddr_a(s_ridx[0]), .raddr_b(s_ridx[1]),
    .rdata_a(con_a), .rdata_b(con_b)
  );

  esrf_bank #(.W(W), .DEPTH(SDEPTH), .AW(SPW)) u_stk (
    .clk(clk), .rst(rst), .we(stk_we), .waddr(d_sidx), .wdata(wr_data),
    .re(op_valid), .raddr_a(s_sidx[0]), .raddr_b(s_sidx[1]),
    .rdata_a(stk_a), .rdata_b(stk_b)
  );

  // registered bank choice, muxed after the bank read registers
  bank_e sel_a_q, sel_b_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_a_q <= BK_NONE;
      sel_b_q <= BK_NONE;
    end else if (op_valid) begin
      sel_a_q <= s_bank[0];
      sel_b_q <= s_bank[1];
    end
  end

  function automatic logic [W-1:0] pick(bank_e b, logic [W-1:0] l, logic [W-1:0] c,
                                        logic [W-1:0] x, logic [W-1:0] s);
    unique case (b)
      BK_LOC:  return l;
      BK_CON:  return c;
      BK_AUX:  return x;
      BK_STK:  return s;
      default: return '0;
    endcase
  endfunction

  assign rd_a_data = pick(sel_a_q, loc_a, con_a, aux_a, stk_a);
  assign rd_b_data = pick(sel_b_q, loc_b, con_b, aux_b, stk_b);

  p_sp_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(sp_q));

  p_sp_hold_illegal_r5: assert property (@(posedge clk) disable iff (rst)
    illegal_c |=> $stable(sp_q));

  p_illegal_after_op_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(illegal) |-> $past(op_valid));

  p_sp_step_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (SPW'(sp_q - $past(sp_q)) inside {SPW'(0), SPW'(1), SPW'(-1), SPW'(-2)}));
endmodule

// File: tb/tb_esrf_top.sv
module tb_esrf_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we;
  logic [3:0] cfg_idx;
  logic [W-1:0] cfg_data;
  logic op_valid, quick_en;
  logic [1:0] quick_code;
  logic [2:0] src_a_kind, src_b_kind, dst_kind;
  logic [3:0] src_a_idx, src_b_idx, dst_idx;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_a_data, rd_b_data;
  logic [6:0] sp;
  logic illegal;

  always #4 clk = ~clk;

  esrf_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .op_valid(op_valid), .quick_en(quick_en), .quick_code(quick_code),
    .src_a_kind(src_a_kind), .src_a_idx(src_a_idx),
    .src_b_kind(src_b_kind), .src_b_idx(src_b_idx),
    .dst_kind(dst_kind), .dst_idx(dst_idx), .wr_data(wr_data),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .sp(sp), .illegal(illegal)
  );

  // behavioural model
  int unsigned m_loc [16];
  int unsigned m_aux [16];
  int unsigned m_con [12];
  int unsigned m_stk [128];
  bit          m_known [128];
  int          m_sp;
  int unsigned e_a, e_b;
  bit          k_a, k_b, e_ill;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "sp", sp, m_sp);
    chk(tag, "illegal", illegal, e_ill);
    if (k_a) chk(tag, "rd_a", rd_a_data, e_a);
    if (k_b) chk(tag, "rd_b", rd_b_data, e_b);
  endtask

  function automatic void src_val(int kind, int idx, output int unsigned v,
                                  output bit known, output int pops);
    int slot;
    pops = 0; known = 1; v = 0;
    case (kind)
      1: v = m_loc[idx];
      2: v = (idx < 12) ? m_con[idx] : 0;
      3: v = m_aux[idx];
      4, 5, 6, 7: begin
        slot = (kind == 5 || kind == 7) ? ((m_sp + 127) % 128) : m_sp;
        v = m_stk[slot];
        known = m_known[slot];
        if (kind >= 6) pops = 1;
      end
      default: v = 0;
    endcase
  endfunction

  task automatic op(string tag, int ak, int ai, int bk, int bi, int dk, int di,
                    int unsigned wd, bit q = 0, int qc = 0);
    int pa, pb, push, delta, slot;
    bit mix;
    @(negedge clk);
    op_valid = 1; quick_en = q; quick_code = 2'(qc);
    src_a_kind = 3'(ak); src_a_idx = 4'(ai);
    src_b_kind = 3'(bk); src_b_idx = 4'(bi);
    dst_kind = 3'(dk); dst_idx = 4'(di); wr_data = wd;
    if (q) begin
      case (qc)
        0: begin ak = 4; dk = 4; end
        1: begin ak = 4; dk = 6; end
        2: begin ak = 2; ai = 0; dk = 6; end
        default: begin ak = 2; ai = 1; dk = 6; end
      endcase
    end
    src_val(ak, ai, e_a, k_a, pa);
    src_val(bk, bi, e_b, k_b, pb);
    mix = (ak == 1 || bk == 1 || dk == 1) && (ak == 3 || bk == 3 || dk == 3);
    e_ill = mix;
    if (!mix) begin
      push = (dk == 6) ? 1 : 0;
      case (dk)
        1: m_loc[di] = wd;
        3: m_aux[di] = wd;
        4, 5, 6: begin
          slot = (dk == 4) ? m_sp : (dk == 5) ? (m_sp + 127) % 128 : (m_sp + 1) % 128;
          m_stk[slot] = wd;
          m_known[slot] = 1;
        end
        default: ;
      endcase
      delta = push - pa - pb;
      m_sp = (m_sp + delta + 128) % 128;
    end
    @(negedge clk);
    op_valid = 0; quick_en = 0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    op_valid = 0;
    src_a_kind = 3'd6; src_b_kind = 3'd7; dst_kind = 3'd6; wr_data = 32'hDEAD;
    e_ill = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cfg(int idx, int unsigned v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_data = v;
    if (idx < 12) m_con[idx] = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    rst = 1; cfg_we = 0; cfg_idx = 0; cfg_data = 0; op_valid = 0; quick_en = 0;
    quick_code = 0; src_a_kind = 0; src_a_idx = 0; src_b_kind = 0; src_b_idx = 0;
    dst_kind = 0; dst_idx = 0; wr_data = 0;
    m_sp = 0; e_a = 0; e_b = 0; k_a = 1; k_b = 1; e_ill = 0;
    foreach (m_known[i]) m_known[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1");

    // R6: constants through configuration port; out-of-range index ignored
    for (int i = 0; i < 12; i++) cfg(i, 32'hC000_0000 + i);
    cfg(13, 32'hBAD0_0013);

    // R3: fill locals and auxiliaries
    for (int i = 0; i < 16; i++) op("R3", 0, 0, 0, 0, 1, i, 32'h1000 + i);
    for (int i = 0; i < 16; i++) op("R3", 0, 0, 0, 0, 3, i, 32'h2000 + i);

    // R2: explicit register reads
    op("R2", 1, 3, 2, 5, 0, 0, 0);
    op("R2", 3, 2, 1, 15, 0, 0, 0);
    op("R6", 2, 13, 2, 11, 0, 0, 0);

    // R4: pushes
    for (int i = 0; i < 6; i++) op("R4", 0, 0, 0, 0, 6, 0, 32'h100 + i);
    op("R2", 4, 0, 5, 0, 0, 0, 0);
    // R4: two pops and a push at the old pointer
    op("R4", 6, 0, 7, 0, 6, 0, 32'hAAAA);
    op("R4", 4, 0, 5, 0, 0, 0, 0);
    // R3: overwrite top and next
    op("R3", 0, 0, 0, 0, 4, 0, 32'h5151);
    op("R3", 4, 0, 0, 0, 5, 0, 32'h5252);
    op("R3", 4, 0, 5, 0, 7, 0, 32'h7777);

    // R6: destination constant ignored
    op("R6", 0, 0, 0, 0, 2, 0, 32'hFFFF);
    op("R6", 2, 0, 2, 1, 0, 0, 0);

    // R5: mixing rule
    op("R5", 1, 1, 0, 0, 3, 2, 32'hBEEF);
    op("R5", 3, 2, 1, 1, 0, 0, 0);
    op("R5", 3, 4, 0, 0, 1, 4, 32'hBEEF);
    op("R5", 1, 4, 3, 4, 0, 0, 0);

    // R7: quick pairings
    op("R7", 0, 0, 5, 0, 0, 0, 32'h7100, 1, 0);
    op("R7", 0, 0, 4, 0, 0, 0, 32'h7101, 1, 1);
    op("R7", 0, 0, 4, 0, 0, 0, 32'h7102, 1, 2);
    op("R7", 0, 0, 4, 0, 0, 0, 32'h7103, 1, 3);
    op("R7", 4, 0, 5, 0, 0, 0, 0);

    // R8: idle cycles hold everything
    idle("R8");
    idle("R8");

    // R4: drain and wrap below zero
    while (m_sp != 1) op("R4", 6, 0, 0, 0, 0, 0, 0);
    op("R4", 6, 0, 7, 0, 0, 0, 0);
    op("R4", 0, 0, 0, 0, 4, 0, 32'h1271);
    op("R4", 4, 0, 0, 0, 6, 0, 32'h0001);
    op("R4", 4, 0, 5, 0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule